// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns a single vector memory request into a stream of per-element addresses, one per cycle. A start pulse captures a base address, an element count, an addressing mode, a 14-bit signed immediate stride, a scalar stride register and a scale select. It then walks the element index from zero upward and presents each index together with its 32-bit address. The next address leaves only once the consumer accepts the current one.

Two modes use a constant stride. In one the stride is the sign-extended immediate. In the other it is the stride register shifted by the scale. Neither mode uses a multiplier: an accumulator starts at the base and adds the stride once per accepted element. The indexed (gather/scatter) mode takes one offset per element over a valid/ready handshake and adds the scaled offset to the base.

Two further load-only modes produce the same stride addresses, but as element results rather than memory accesses. A flag output marks such beats. A done pulse closes every request, including empty and rejected ones.

Top module: `vec_addr_seq`

## Requirements
- R1: Mode code 0 (immediate stride): element k's address is base + sign_extend(imm14) * k, modulo 2^32, so element 0 is exactly the base.
- R2: Mode code 1 (register stride): element k's address is base + (stride_reg << scale_sel) * k, modulo 2^32. Scale select 0, 1, 2 and 3 means a factor of 1, 2, 4 and 8.
- R3: Mode code 2 (indexed): element k's address is base + (offset_k << scale_sel), modulo 2^32. The element is valid only while off_valid_i is high, and the address appears combinationally in that same cycle. off_ready_o equals out_ready_i while an indexed request is active and is 0 otherwise.
- R4: Mode codes 3 and 4 produce the addresses of modes 0 and 1 respectively, with elem_is_data_o = 1 to mark them as results rather than accesses. Modes 0 to 2 give elem_is_data_o = 0.
- R5: A start with an illegal request emits no element and pulses done_o in the following cycle. Illegal means mode code 5, 6 or 7, or mode code 3 or 4 with is_store_i = 1.
- R6: Element indices run 0, 1, ..., len-1 in order. done_o is high for exactly one cycle, the cycle after the last element is accepted.
- R7: A start with len_i = 0 emits no element and pulses done_o in the following cycle.
- R8: A start that arrives while a request is active has no effect. The active request runs to its own length with its own base and stride.
- R9: While out_ready_i is low, a valid element holds. Its index stays the same, and so does its address in the stride modes. No element is consumed.
- R10: While reset is high and in the cycle after it, elem_valid_o, done_o and off_ready_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request start pulse |
| len_i | input | LEN_W | Element count |
| base_i | input | 32 | Scalar base address |
| mode_i | input | 3 | Mode code (0 imm stride, 1 reg stride, 2 indexed, 3 EA imm, 4 EA reg) |
| is_store_i | input | 1 | Request is a store |
| imm_stride_i | input | 14 | Signed immediate stride |
| reg_stride_i | input | 32 | Scalar stride register value |
| scale_i | input | 2 | Scale select, factor 1 << scale_i |
| off_valid_i | input | 1 | Per-element offset valid |
| off_data_i | input | 32 | Per-element offset value |
| off_ready_o | output | 1 | Offset accepted this cycle when high with off_valid_i |
| out_ready_i | input | 1 | Consumer ready for the element |
| elem_valid_o | output | 1 | Element index and address valid |
| elem_idx_o | output | LEN_W | Element index k |
| elem_addr_o | output | 32 | Element address or computed value |
| elem_is_data_o | output | 1 | Beat is a result value, not a memory access |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
After the clock edge that samples start, element 0 is due in that same cycle. Each later element is due in the cycle after the edge that accepted the previous one. done_o is due one cycle after the last acceptance, or one cycle after start for an empty or illegal request. In indexed mode the address follows off_data_i in the same cycle. The bench drives inputs shortly after each rising edge and advances its behavioural model at the rising edge. It compares every output against the model on the falling edge, when both combinational and registered results have settled.

// File: rtl/vas_pkg.sv
package vas_pkg;

    localparam int ADDR_W = 32;
    localparam int IMM_W  = 14;
    localparam int MODE_W = 3;
    localparam int SCL_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        VM_IMM_STRIDE = 3'd0,
        VM_REG_STRIDE = 3'd1,
        VM_INDEXED    = 3'd2,
        VM_EA_IMM     = 3'd3,
        VM_EA_REG     = 3'd4
    } vmode_e;

    typedef struct packed {
        vmode_e            mode;
        logic [ADDR_W-1:0] base;
        logic [SCL_W-1:0]  scale;
    } vcfg_t;

    function automatic logic [ADDR_W-1:0] scale_by(input logic [ADDR_W-1:0] v,
                                                   input logic [SCL_W-1:0]  sel);
        return v << sel;
    endfunction

    function automatic logic [ADDR_W-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic mode_legal(input logic [MODE_W-1:0] m, input logic store);
        logic ok;
        case (m)
            VM_IMM_STRIDE, VM_REG_STRIDE, VM_INDEXED: ok = 1'b1;
            VM_EA_IMM, VM_EA_REG:                     ok = !store;
            default:                                  ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic mode_uses_reg(input logic [MODE_W-1:0] m);
        return (m == VM_REG_STRIDE) || (m == VM_EA_REG);
    endfunction

    function automatic logic mode_is_ea(input vmode_e m);
        return (m == VM_EA_IMM) || (m == VM_EA_REG);
    endfunction

endpackage

// File: rtl/vas_step_gen.sv
module vas_step_gen
    import vas_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [SCL_W-1:0]  scale_i,
    output logic [ADDR_W-1:0] step_o
);
    always_comb begin
        if (mode_uses_reg(mode_i)) begin
            step_o = scale_by(reg_i, scale_i);
        end else if (mode_i == VM_INDEXED) begin
            step_o = '0;
        end else begin
            step_o = sext_imm(imm_i);
        end
    end
endmodule

// File: rtl/vas_accum.sv
module vas_accum
    import vas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] step_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] acc_o
);
    logic [ADDR_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o  <= '0;
            step_q <= '0;
        end else if (load_i) begin
            acc_o  <= base_i;
            step_q <= step_i;
        end else if (adv_i) begin
            acc_o  <= acc_o + step_q;
        end
    end

    // Element 0 of a stride sequence is the captured base.
    assert_first_is_base_R1: assert property (@(posedge clk) disable iff (rst)
        load_i |=> acc_o == $past(base_i));

    assert_acc_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i) |=> acc_o == $past(acc_o) + $past(step_q));
endmodule

// File: rtl/vas_ctrl.sv
module vas_ctrl
    import vas_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             legal_i,
    input  logic             fire_i,
    output logic             accept_o,
    output logic             active_o,
    output logic [LEN_W-1:0] idx_o,
    output logic             done_o
);
    logic [LEN_W-1:0] last_q;
    logic             at_last;

    assign at_last  = (idx_o == last_q);
    assign accept_o = !active_o && start_i && legal_i && (len_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            idx_o    <= '0;
            last_q   <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (active_o) begin
                if (fire_i) begin
                    if (at_last) begin
                        active_o <= 1'b0;
                        done_o   <= 1'b1;
                    end else begin
                        idx_o <= idx_o + 1'b1;
                    end
                end
            end else if (start_i) begin
                if (accept_o) begin
                    active_o <= 1'b1;
                    idx_o    <= '0;
                    last_q   <= len_i - 1'b1;
                end else begin
                    done_o <= 1'b1;
                end
            end
        end
    end

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        (active_o && fire_i && at_last) |=> (done_o && !active_o));

    assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
        (active_o && fire_i && !at_last) |=> (idx_o == $past(idx_o) + 1'b1));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (active_o && start_i && !fire_i) |=> (active_o && $stable(idx_o)));

    assert_len_zero_done_R7: assert property (@(posedge clk) disable iff (rst)
        (!active_o && start_i && len_i == '0) |=> (done_o && !active_o));

    assert_reject_done_R5: assert property (@(posedge clk) disable iff (rst)
        (!active_o && start_i && !legal_i) |=> (done_o && !active_o));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!done_o && !active_o));
endmodule

// File: rtl/vec_addr_seq.sv
module vec_addr_seq
    import vas_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              is_store_i,
    input  logic [IMM_W-1:0]  imm_stride_i,
    input  logic [ADDR_W-1:0] reg_stride_i,
    input  logic [SCL_W-1:0]  scale_i,
    input  logic              off_valid_i,
    input  logic [ADDR_W-1:0] off_data_i,
    output logic              off_ready_o,
    input  logic              out_ready_i,
    output logic              elem_valid_o,
    output logic [LEN_W-1:0]  elem_idx_o,
    output logic [ADDR_W-1:0] elem_addr_o,
    output logic              elem_is_data_o,
    output logic              done_o
);
    vcfg_t             cfg_q;
    logic              accept, active, fire, legal, indexed;
    logic [ADDR_W-1:0] step, acc, gather_addr;

    assign legal = mode_legal(mode_i, is_store_i);

    vas_step_gen u_step (
        .mode_i  (mode_i),
        .imm_i   (imm_stride_i),
        .reg_i   (reg_stride_i),
        .scale_i (scale_i),
        .step_o  (step)
    );

    vas_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .len_i    (len_i),
        .legal_i  (legal),
        .fire_i   (fire),
        .accept_o (accept),
        .active_o (active),
        .idx_o    (elem_idx_o),
        .done_o   (done_o)
    );

    vas_accum u_acc (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .base_i (base_i),
        .step_i (step),
        .adv_i  (fire),
        .acc_o  (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode  <= VM_IMM_STRIDE;
            cfg_q.base  <= '0;
            cfg_q.scale <= '0;
        end else if (accept) begin
            cfg_q.mode  <= vmode_e'(mode_i);
            cfg_q.base  <= base_i;
            cfg_q.scale <= scale_i;
        end
    end

    assign indexed        = (cfg_q.mode == VM_INDEXED);
    assign gather_addr    = cfg_q.base + scale_by(off_data_i, cfg_q.scale);
    assign elem_valid_o   = active && (!indexed || off_valid_i);
    assign fire           = elem_valid_o && out_ready_i;
    assign off_ready_o    = active && indexed && out_ready_i;
    assign elem_addr_o    = indexed ? gather_addr : acc;
    assign elem_is_data_o = mode_is_ea(cfg_q.mode);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (elem_valid_o && !out_ready_i) |=> $stable(elem_idx_o));

    assert_stall_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (elem_valid_o && !out_ready_i && !indexed) |=> $stable(elem_addr_o));

    assert_offset_gates_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (off_ready_o && off_valid_i) |-> (elem_valid_o && out_ready_i));

    assert_done_not_valid_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !elem_valid_o);
endmodule

// File: tb/tb_vec_addr_seq.sv
module tb_vec_addr_seq;
    localparam int LEN_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic [31:0] base_i = '0;
    logic [2:0] mode_i = '0;
    logic is_store_i = 1'b0;
    logic [13:0] imm_stride_i = '0;
    logic [31:0] reg_stride_i = '0;
    logic [1:0] scale_i = '0;
    logic off_valid_i = 1'b0;
    logic [31:0] off_data_i = '0;
    logic off_ready_o;
    logic out_ready_i = 1'b1;
    logic elem_valid_o;
    logic [LEN_W-1:0] elem_idx_o;
    logic [31:0] elem_addr_o;
    logic elem_is_data_o;
    logic done_o;

    vec_addr_seq #(.LEN_W(LEN_W)) dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, emitted = 0, cycles = 0;
    bit rdy_rand = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_act = 0, m_done = 0;
    int m_k = 0, m_len = 0, m_mode = 0, m_scale = 0;
    logic [31:0] m_base = '0, m_step = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] step_of(input int md, input logic [13:0] imm,
                                            input logic [31:0] rs, input int sc);
        if (md == 1 || md == 4) return rs * (32'd1 << sc);
        return {{18{imm[13]}}, imm};
    endfunction

    // model update at the edge
    always @(posedge clk) begin
        bit v;
        if (rst) begin
            m_act = 0; m_done = 0; m_k = 0;
        end else begin
            m_done = 0;
            if (m_act) begin
                v = (m_mode == 2) ? off_valid_i : 1'b1;
                if (v && out_ready_i) begin
                    if (m_k == m_len - 1) begin m_act = 0; m_done = 1; end
                    else m_k++;
                end
            end else if (start_i) begin
                if (mode_i > 4 || (mode_i >= 3 && is_store_i) || len_i == 0) m_done = 1;
                else begin
                    m_act = 1; m_k = 0; m_len = len_i; m_mode = mode_i;
                    m_base = base_i; m_scale = scale_i;
                    m_step = step_of(mode_i, imm_stride_i, reg_stride_i, scale_i);
                end
            end
        end
    end

    // handshake-side drivers, changed just after each edge
    always @(posedge clk) begin
        bit took;
        took = off_valid_i && off_ready_o;
        #1;
        out_ready_i <= rdy_rand ? 1'($urandom % 2) : 1'b1;
        if (!off_valid_i || took) begin
            off_valid_i <= ($urandom % 10) < 7;
            off_data_i  <= $urandom;
        end
    end

    // compare against the model away from the edge
    always @(negedge clk) begin
        logic exp_v;
        logic [31:0] exp_a;
        if (!rst && !finished) begin
            exp_v = m_act && ((m_mode == 2) ? off_valid_i : 1'b1);
            chk("R6 done", done_o, m_done);
            chk("R9 valid", elem_valid_o, exp_v);
            chk("R3 off_ready", off_ready_o, m_act && m_mode == 2 && out_ready_i);
            if (exp_v) begin
                if (m_mode == 2) exp_a = m_base + off_data_i * (32'd1 << m_scale);
                else             exp_a = m_base + m_step * m_k;
                chk("R6 idx", 32'(elem_idx_o), m_k);
                case (m_mode)
                    0: chk("R1 addr", elem_addr_o, exp_a);
                    1: chk("R2 addr", elem_addr_o, exp_a);
                    2: chk("R3 addr", elem_addr_o, exp_a);
                    default: chk("R4 addr", elem_addr_o, exp_a);
                endcase
                chk("R4 is_data", elem_is_data_o, m_mode >= 3);
                if (out_ready_i) emitted++;
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            summary();
        end
    end

    task automatic drive_start(input int md, input int len, input logic [31:0] base,
                               input logic [13:0] imm, input logic [31:0] rs,
                               input int sc, input bit st);
        @(posedge clk); #1;
        start_i = 1; mode_i = 3'(md); len_i = LEN_W'(len); base_i = base;
        imm_stride_i = imm; reg_stride_i = rs; scale_i = 2'(sc); is_store_i = st;
        @(posedge clk); #1;
        start_i = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done_o) break;
        end
        @(negedge clk);
    endtask

    task automatic run(input string tag, input int md, input int len, input logic [31:0] base,
                       input logic [13:0] imm, input logic [31:0] rs, input int sc,
                       input bit st, input int exp_n);
        int e0;
        e0 = emitted;
        drive_start(md, len, base, imm, rs, sc, st);
        wait_done();
        chk(tag, emitted - e0, exp_n);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R10 valid after reset", elem_valid_o, 0);
        chk("R10 done after reset", done_o, 0);
        chk("R10 off_ready after reset", off_ready_o, 0);

        run("R1 count", 0, 6, 32'h1000, 14'd5, 0, 0, 0, 6);
        run("R1 negative count", 0, 4, 32'h100, 14'h2000, 0, 0, 1, 4);
        for (int sc = 0; sc < 4; sc++)
            run("R2 count", 1, 5, 32'h8000_0000, 14'd0, 32'h0000_0013, sc, 0, 5);
        run("R2 negative count", 1, 3, 32'h40, 14'd0, 32'hFFFF_FFFC, 3, 1, 3);
        run("R3 count", 2, 7, 32'h2000, 14'd0, 0, 2, 0, 7);
        run("R3 scale1 count", 2, 5, 32'hFFFF_FF00, 14'd0, 0, 0, 1, 5);
        run("R4 ea imm count", 3, 4, 32'h300, 14'h3FFF, 0, 0, 0, 4);
        run("R4 ea reg count", 4, 4, 32'h300, 14'd0, 32'h10, 1, 0, 4);
        run("R5 ea store rejected", 3, 4, 32'h300, 14'd4, 0, 0, 1, 0);
        run("R5 ea reg store rejected", 4, 4, 32'h300, 14'd4, 4, 0, 1, 0);
        run("R5 bad mode rejected", 6, 4, 32'h300, 14'd4, 0, 0, 0, 0);
        run("R7 zero length", 0, 0, 32'h500, 14'd4, 0, 0, 0, 0);
        run("R6 single element", 1, 1, 32'hABC, 14'd0, 32'h7, 3, 0, 1);

        rdy_rand = 1;
        run("R9 stalled imm count", 0, 9, 32'h10, 14'd12, 0, 0, 0, 9);
        run("R9 stalled gather count", 2, 9, 32'h20, 14'd0, 0, 3, 1, 9);
        run("R9 stalled ea count", 4, 6, 32'h20, 14'd0, 32'h9, 2, 0, 6);
        rdy_rand = 0;

        begin : r8_blk
            int e0;
            e0 = emitted;
            rdy_rand = 1;
            drive_start(0, 5, 32'h4000, 14'd8, 0, 0, 0);
            @(posedge clk); #1;
            start_i = 1; base_i = 32'h9999_0000; len_i = 8'd50; mode_i = 3'd1;
            @(posedge clk); #1;
            start_i = 0;
            wait_done();
            rdy_rand = 0;
            chk("R8 restart ignored count", emitted - e0, 5);
        end

        repeat (4) @(posedge clk);
        summary();
    end
endmodule